// File: doc/BRIEF.md
# Constrained Transaction Limit Monitor

This block watches a constrained transaction, meaning one that the hardware promises will complete, as the core executes it. A begin pulse opens the transaction and latches the begin PC. While the transaction is open, the monitor takes three inputs from the core: each retired instruction (its PC, whether it was a taken branch, and the branch target), each data access address, and an end pulse. It checks the transaction against fixed limits. These are the number of distinct 32-byte data blocks, the number of retired instructions, backward taken branches, the span of code from the begin PC, and data accesses that fall into a page holding the transaction's code.

Breaking a limit is a program exception. The monitor reports it as a one-cycle violation pulse with a cause code, and the transaction is dropped without a retry. An abort from outside, such as a conflict found elsewhere, is handled differently. The monitor asks the core to restart at the begin PC and counts the retry. The retry count drives an escalation level that the core uses to throttle speculation, and a random delay value masked by that level. When a transaction ends successfully, the retry history and all tracking state are cleared.

Top module: `ctxn_limit_mon`

## Requirements
- R1: Data blocks are identified by address bits [31:5]. Up to four distinct blocks may be touched per transaction. Further accesses to an already recorded block use no new entry. An access to a fifth distinct block is violation cause 1.
- R2: Up to 32 retirements are allowed per transaction. The 33rd retirement is violation cause 2.
- R3: A retirement marked taken whose target is strictly below its PC is violation cause 3. A target equal to or above the PC is allowed, and so is a not-taken retirement with any target.
- R4: A retirement whose PC minus the begin PC, taken modulo 2^32, is 256 or more is violation cause 4. This includes any PC below the begin PC.
- R5: A data access whose address bits [31:12] equal those of the begin PC, or those of begin PC + 255, is violation cause 5.
- R6: A violation shows as `viol_o` high for exactly the cycle after the offending input, with the code on `viol_cause_o`. When several causes hit in one cycle, the lowest code wins. A violation closes the transaction, clears the retry count and raises no restart, even if abort or end arrives in the same cycle.
- R7: An abort while a transaction is open and not violating makes `restart_o` pulse in the next cycle, with `restart_pc_o` equal to the most recent begin PC. It closes the transaction and adds one to a retry count that saturates at 15. Abort wins over end in the same cycle.
- R8: `esc_level_o` is 0 for a retry count of 0 to 1, 1 for 2 to 3, 2 for 4 to 7, and 3 for 8 or more.
- R9: `delay_o` is a free-running 16-bit LFSR value ANDed with a mask chosen by level: 0x0000, 0x000F, 0x00FF or 0x0FFF for levels 0 to 3.
- R10: An end with no abort or violation clears the retry count and releases all data-block entries.
- R11: With no transaction open, retire, access, end and abort inputs have no effect. A begin always starts fresh tracking, keeps the retry count, and causes every other input in its own cycle to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_i | input | 1 | Constrained transaction begin pulse |
| begin_pc_i | input | 32 | PC of the begin instruction |
| ret_valid_i | input | 1 | An instruction retired this cycle |
| ret_pc_i | input | 32 | PC of the retired instruction |
| ret_taken_i | input | 1 | Retired instruction is a taken branch |
| ret_target_i | input | 32 | Branch target of the retired instruction |
| mem_valid_i | input | 1 | A data access occurred this cycle |
| mem_addr_i | input | 32 | Data access byte address |
| end_i | input | 1 | Transaction end pulse |
| abort_i | input | 1 | External abort request |
| viol_o | output | 1 | Limit violation pulse |
| viol_cause_o | output | 3 | Violation cause code (1 to 5) |
| restart_o | output | 1 | Restart request pulse |
| restart_pc_o | output | 32 | Address at which to restart |
| esc_level_o | output | 2 | Speculation throttle level |
| delay_o | output | 16 | Masked random delay cycle count |

## Verification
The bench goes after the exact limit edges. A count that is off by one would accept a 33rd instruction or a 256-byte offset, or would flag the 32nd. A tracker that keys on full addresses would use up an entry for a second access inside the same 32-byte block. The bench builds a code region that crosses a 4 KB boundary, so a check that only looks at the begin PC's page misses the second page. It sweeps the abort count past the saturation point, where a counter that wraps would drop the level back to 0. It also makes violations collide with abort and end, and with each other, where a wrong priority shows up as a spurious restart or the wrong cause code.

// File: rtl/ctxn_pkg.sv
package ctxn_pkg;

  typedef enum logic [2:0] {
    CZ_NONE      = 3'd0,
    CZ_DATA_BLKS = 3'd1,
    CZ_INSN_CNT  = 3'd2,
    CZ_BACK_BR   = 3'd3,
    CZ_CODE_SPAN = 3'd4,
    CZ_PAGE_MIX  = 3'd5
  } cause_e;

  // Escalation level from retry count (R8)
  function automatic logic [1:0] esc_of(input int unsigned n);
    if (n >= 8)      return 2'd3;
    else if (n >= 4) return 2'd2;
    else if (n >= 2) return 2'd1;
    else             return 2'd0;
  endfunction

  // Delay mask per level (R9)
  function automatic logic [31:0] delay_mask(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 32'h0000_0000;
      2'd1:    return 32'h0000_000F;
      2'd2:    return 32'h0000_00FF;
      default: return 32'h0000_0FFF;
    endcase
  endfunction

endpackage

// File: rtl/ctxn_blk_tbl.sv
module ctxn_blk_tbl #(
  parameter int TAG_W   = 27,
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               alloc_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               hit_o,
  output logic               full_o,
  output logic [ENTRIES-1:0] vld_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] sel;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign match[e] = vld_q[e] && (tag_q[e] == tag_i);
    always_ff @(posedge clk) begin
      if (!rst_n)                tag_q[e] <= '0;
      else if (alloc_i && sel[e]) tag_q[e] <= tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (clr_i)   vld_q <= '0;
    else if (alloc_i) vld_q <= vld_q | sel;
  end

  assign hit_o  = |match;
  assign full_o = &vld_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/ctxn_retry_esc.sv
module ctxn_retry_esc #(
  parameter int          RETRY_W = 4,
  parameter int          LFSR_W  = 16,
  parameter logic [15:0] TAPS    = 16'hB400,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              clr_i,
  output logic [1:0]        level_o,
  output logic [LFSR_W-1:0] delay_o
);
  import ctxn_pkg::*;
  localparam logic [RETRY_W-1:0] RMAX = '1;

  logic [RETRY_W-1:0] retry_q;
  logic [LFSR_W-1:0]  lfsr_q;
  logic [31:0]        mask;

  always_ff @(posedge clk) begin
    if (!rst_n)                         retry_q <= '0;
    else if (clr_i)                     retry_q <= '0;
    else if (inc_i && retry_q != RMAX)  retry_q <= retry_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
    else        lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS[LFSR_W-1:0] : '0);
  end

  assign level_o = esc_of(int'(retry_q));
  assign mask    = delay_mask(level_o);
  assign delay_o = lfsr_q & mask[LFSR_W-1:0];
endmodule

// File: rtl/ctxn_limit_mon.sv
module ctxn_limit_mon #(
  parameter int ADDR_W     = 32,
  parameter int MAX_BLOCKS = 4,
  parameter int MAX_INSNS  = 32,
  parameter int CODE_BYTES = 256,
  parameter int BLK_BYTES  = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int RETRY_W    = 4,
  parameter int LFSR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic [ADDR_W-1:0] begin_pc_i,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic              ret_taken_i,
  input  logic [ADDR_W-1:0] ret_target_i,
  input  logic              mem_valid_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              end_i,
  input  logic              abort_i,
  output logic              viol_o,
  output logic [2:0]        viol_cause_o,
  output logic              restart_o,
  output logic [ADDR_W-1:0] restart_pc_o,
  output logic [1:0]        esc_level_o,
  output logic [LFSR_W-1:0] delay_o
);
  import ctxn_pkg::*;

  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam int PG_SH  = $clog2(PAGE_BYTES);
  localparam int TAG_W  = ADDR_W - BLK_SH;
  localparam int CNT_W  = $clog2(MAX_INSNS + 1);

  function automatic logic [ADDR_W-PG_SH-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PG_SH];
  endfunction

  function automatic logic span_exceeded(input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = pc - base;
    return off >= ADDR_W'(CODE_BYTES);
  endfunction

  function automatic logic in_code_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] last;
    last = base + ADDR_W'(CODE_BYTES - 1);
    return (page_of(a) == page_of(base)) || (page_of(a) == page_of(last));
  endfunction

  logic              active_q;
  logic [ADDR_W-1:0] bpc_q;
  logic [CNT_W-1:0]  icnt_q;

  // Named internal events
  logic ret_ev, mem_ev;
  logic c_blk, c_cnt, c_bwd, c_code, c_page;
  logic any_viol, abort_ev, done_ev, blk_alloc, trk_clr;
  logic blk_hit, blk_full;
  logic [MAX_BLOCKS-1:0] blk_vld;
  cause_e cause_n;

  assign ret_ev = active_q && ret_valid_i && !begin_i;
  assign mem_ev = active_q && mem_valid_i && !begin_i;

  assign c_blk  = mem_ev && !blk_hit && blk_full;
  assign c_cnt  = ret_ev && (icnt_q == CNT_W'(MAX_INSNS));
  assign c_bwd  = ret_ev && ret_taken_i && (ret_target_i < ret_pc_i);
  assign c_code = ret_ev && span_exceeded(ret_pc_i, bpc_q);
  assign c_page = mem_ev && in_code_page(mem_addr_i, bpc_q);

  assign any_viol  = c_blk || c_cnt || c_bwd || c_code || c_page;
  assign abort_ev  = active_q && abort_i && !begin_i && !any_viol;
  assign done_ev   = active_q && end_i && !begin_i && !any_viol && !abort_i;
  assign blk_alloc = mem_ev && !blk_hit && !blk_full;
  assign trk_clr   = begin_i || any_viol || abort_ev || done_ev;

  always_comb begin
    if (c_blk)       cause_n = CZ_DATA_BLKS;
    else if (c_cnt)  cause_n = CZ_INSN_CNT;
    else if (c_bwd)  cause_n = CZ_BACK_BR;
    else if (c_code) cause_n = CZ_CODE_SPAN;
    else if (c_page) cause_n = CZ_PAGE_MIX;
    else             cause_n = CZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      bpc_q        <= '0;
      icnt_q       <= '0;
      viol_o       <= 1'b0;
      viol_cause_o <= 3'd0;
      restart_o    <= 1'b0;
    end else begin
      viol_o       <= any_viol;
      viol_cause_o <= any_viol ? cause_n : 3'd0;
      restart_o    <= abort_ev;
      if (begin_i) begin
        active_q <= 1'b1;
        bpc_q    <= begin_pc_i;
        icnt_q   <= '0;
      end else begin
        if (any_viol || abort_ev || done_ev) active_q <= 1'b0;
        if (ret_ev && !any_viol)             icnt_q   <= icnt_q + 1'b1;
      end
    end
  end

  assign restart_pc_o = bpc_q;

  ctxn_blk_tbl #(.TAG_W(TAG_W), .ENTRIES(MAX_BLOCKS)) blk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (trk_clr),
    .alloc_i(blk_alloc),
    .tag_i  (mem_addr_i[ADDR_W-1:BLK_SH]),
    .hit_o  (blk_hit),
    .full_o (blk_full),
    .vld_o  (blk_vld)
  );

  ctxn_retry_esc #(.RETRY_W(RETRY_W), .LFSR_W(LFSR_W)) esc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (abort_ev),
    .clr_i  (done_ev || any_viol),
    .level_o(esc_level_o),
    .delay_o(delay_o)
  );
endmodule

// File: rtl/ctxn_limit_mon_chk.sv
module ctxn_limit_mon_chk #(
  parameter int CNT_W     = 6,
  parameter int MAX_INSNS = 32,
  parameter int BLKS      = 4,
  parameter int LFSR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              viol_o,
  input logic [2:0]        viol_cause_o,
  input logic              restart_o,
  input logic [1:0]        esc_level_o,
  input logic [LFSR_W-1:0] delay_o,
  input logic [CNT_W-1:0]  icnt,
  input logic [BLKS-1:0]   blk_vld,
  input logic              abort_ev,
  input logic              done_ev
);
  a_r6_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_cause_o >= 3'd1 && viol_cause_o <= 3'd5));
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> !restart_o);
  a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> restart_o);
  a_r8_esc_up: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> esc_level_o >= $past(esc_level_o));
  a_r2_icnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    icnt <= CNT_W'(MAX_INSNS));
  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (esc_level_o == 2'd0 && blk_vld == '0));
  a_r9_mask_l0: assert property (@(posedge clk) disable iff (!rst_n)
    esc_level_o == 2'd0 |-> delay_o == '0);
endmodule

bind ctxn_limit_mon ctxn_limit_mon_chk #(
  .CNT_W(CNT_W), .MAX_INSNS(MAX_INSNS), .BLKS(MAX_BLOCKS), .LFSR_W(LFSR_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .viol_o      (viol_o),
  .viol_cause_o(viol_cause_o),
  .restart_o   (restart_o),
  .esc_level_o (esc_level_o),
  .delay_o     (delay_o),
  .icnt        (icnt_q),
  .blk_vld     (blk_vld),
  .abort_ev    (abort_ev),
  .done_ev     (done_ev)
);

// File: tb/ctxn_limit_mon_tb.sv
module ctxn_limit_mon_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b = 0, rv = 0, rt = 0, mv = 0, e = 0, ab = 0;
  logic [31:0] bpc = 0, rpc = 0, rtgt = 0, ma = 0;
  logic        viol, rst_o;
  logic [2:0]  cause;
  logic [31:0] rpc_o;
  logic [1:0]  lvl;
  logic [15:0] dly;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ctxn_limit_mon dut_i (
    .clk(clk), .rst_n(rst_n), .begin_i(b), .begin_pc_i(bpc),
    .ret_valid_i(rv), .ret_pc_i(rpc), .ret_taken_i(rt), .ret_target_i(rtgt),
    .mem_valid_i(mv), .mem_addr_i(ma), .end_i(e), .abort_i(ab),
    .viol_o(viol), .viol_cause_o(cause), .restart_o(rst_o), .restart_pc_o(rpc_o),
    .esc_level_o(lvl), .delay_o(dly)
  );

  function automatic int exp_lvl(input int n);
    int m;
    m = (n > 15) ? 15 : n;
    if (m >= 8) return 3;
    if (m >= 4) return 2;
    if (m >= 2) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic b_, input logic [31:0] bpc_, input logic rv_,
                     input logic [31:0] rpc_, input logic rt_, input logic [31:0] rtgt_,
                     input logic mv_, input logic [31:0] ma_, input logic e_, input logic ab_);
    @(negedge clk);
    b = b_; bpc = bpc_; rv = rv_; rpc = rpc_; rt = rt_; rtgt = rtgt_;
    mv = mv_; ma = ma_; e = e_; ab = ab_;
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle();                 drv(0,0,0,0,0,0,0,0,0,0); endtask
  task automatic t_begin(input logic [31:0] p); drv(1,p,0,0,0,0,0,0,0,0); endtask
  task automatic t_ret(input logic [31:0] p, input logic tk, input logic [31:0] tg);
    drv(0,0,1,p,tk,tg,0,0,0,0);
  endtask
  task automatic t_mem(input logic [31:0] a); drv(0,0,0,0,0,0,1,a,0,0); endtask
  task automatic t_end();                  drv(0,0,0,0,0,0,0,0,1,0); endtask
  task automatic t_abort();                drv(0,0,0,0,0,0,0,0,0,1); endtask

  task automatic exp_viol(input string tag, input int c);
    chk(viol === 1'b1 && cause === 3'(c) && rst_o === 1'b0, tag, {viol, cause}, {1'b1, 3'(c)});
  endtask
  task automatic exp_clean(input string tag);
    chk(viol === 1'b0 && rst_o === 1'b0, tag, {viol, rst_o}, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit seen_nz;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(viol === 0 && rst_o === 0 && lvl === 0 && dly === 0, "reset", {viol, rst_o, lvl, dly}, 0);

    // R2 instruction count edge
    t_begin(32'h0001_0000); exp_clean("R2 begin");
    for (int k = 0; k < 32; k++) begin
      t_ret(32'h0001_0000 + 32'(4*k), 0, 0); exp_clean("R2 within limit");
    end
    t_ret(32'h0001_0080, 0, 0); exp_viol("R2 33rd retirement", 2);
    t_idle(); chk(viol === 0, "R6 pulse one cycle", viol, 0);
    t_ret(32'h0001_0000, 1, 0); exp_clean("R11 retire after close ignored");

    // R3 backward branch
    t_begin(32'h0002_0000);
    t_ret(32'h0002_0010, 1, 32'h0002_0010); exp_clean("R3 equal target");
    t_ret(32'h0002_0014, 1, 32'h0002_0040); exp_clean("R3 forward");
    t_ret(32'h0002_0018, 0, 32'h0002_0000); exp_clean("R3 not taken");
    t_ret(32'h0002_001C, 1, 32'h0002_001B); exp_viol("R3 backward", 3);

    // R4 code span
    t_begin(32'h0003_0000);
    t_ret(32'h0003_00FF, 0, 0); exp_clean("R4 offset 255");
    t_ret(32'h0003_0100, 0, 0); exp_viol("R4 offset 256", 4);
    t_begin(32'h0003_0000);
    t_ret(32'h0002_FFFC, 0, 0); exp_viol("R4 below begin", 4);

    // R1 data blocks
    t_begin(32'h0004_0000);
    for (int k = 0; k < 4; k++) begin
      t_mem(32'h0005_0000 + 32'(32*k)); exp_clean("R1 new block");
    end
    for (int k = 0; k < 4; k++) begin
      t_mem(32'h0005_001F + 32'(32*k)); exp_clean("R1 repeat block");
    end
    t_mem(32'h0005_0080); exp_viol("R1 fifth block", 1);
    t_begin(32'h0004_0000);
    t_mem(32'h0005_001F); t_mem(32'h0005_0020); t_mem(32'h0005_0040); t_mem(32'h0005_0060);
    exp_clean("R1 boundary fill");
    t_mem(32'h0005_0000); exp_clean("R1 same block low byte");
    t_mem(32'h0005_0080); exp_viol("R1 fifth after boundary", 1);

    // R5 page overlap, code crossing a page
    t_begin(32'h0000_5F80); t_mem(32'h0000_5000); exp_viol("R5 first code page", 5);
    t_begin(32'h0000_5F80); t_mem(32'h0000_6FFF); exp_viol("R5 second code page", 5);
    t_begin(32'h0000_5F80);
    t_mem(32'h0000_7000); exp_clean("R5 page above");
    t_mem(32'h0000_4FFF); exp_clean("R5 page below");
    t_end(); exp_clean("R5 end");
    t_begin(32'h0000_5000); t_mem(32'h0000_5FFF); exp_viol("R5 single page", 5);
    t_begin(32'h0000_5000); t_mem(32'h0000_6000); exp_clean("R5 next page ok");

    // R6 priorities
    t_begin(32'h0000_8000);
    for (int k = 0; k < 4; k++) t_mem(32'h0001_0000 + 32'(32*k));
    t_mem(32'h0000_8100); exp_viol("R6 blocks over page", 1);
    t_begin(32'h0000_9000);
    drv(0,0,1,32'h0000_9200,0,0,1,32'h0000_9000,0,0); exp_viol("R6 code over page", 4);
    t_begin(32'h0000_9000);
    t_ret(32'h0000_9100, 1, 32'h0000_9000); exp_viol("R6 backward over code", 3);
    t_begin(32'h0000_A000);
    drv(0,0,1,32'h0000_A100,0,0,0,0,0,1); exp_viol("R6 viol beats abort", 4);
    chk(lvl === 0, "R6 no retry counted", lvl, 0);
    t_begin(32'h0000_A000);
    drv(0,0,1,32'h0000_A100,0,0,0,0,1,0); exp_viol("R6 viol beats end", 4);

    // R7/R8 escalation sweep incl. saturation
    for (int k = 1; k <= 17; k++) begin
      t_begin(32'h0000_C000); exp_clean("R7 begin");
      t_abort();
      chk(rst_o === 1 && viol === 0 && rpc_o === 32'h0000_C000, "R7 restart", {rst_o, rpc_o}, {1'b1, 32'h0000_C000});
      chk(lvl === 2'(exp_lvl(k)), "R8 level", lvl, exp_lvl(k));
      chk((32'(dly) & ~(exp_lvl(k) == 0 ? 32'h0 : exp_lvl(k) == 1 ? 32'hF : exp_lvl(k) == 2 ? 32'hFF : 32'hFFF)) == 0,
          "R9 mask", dly, 0);
      t_idle(); chk(rst_o === 0, "R7 pulse one cycle", rst_o, 0);
    end

    // R9 at level 3
    seen_nz = 0;
    for (int k = 0; k < 24; k++) begin
      t_idle();
      chk((dly & 16'hF000) == 0, "R9 level3 mask", dly, 0);
      if (dly != 0) seen_nz = 1;
    end
    chk(seen_nz, "R9 delay varies", seen_nz, 1);

    // R11 inactive inputs ignored
    t_end(); chk(lvl === 3, "R11 end ignored", lvl, 3);
    t_abort(); chk(rst_o === 0 && lvl === 3, "R11 abort ignored", {rst_o, lvl}, 3);
    t_mem(32'h0000_C000); exp_clean("R11 access ignored");

    // R6 violation clears retry
    t_begin(32'h0000_C000);
    t_ret(32'h0000_C010, 1, 32'h0000_C000); exp_viol("R6 viol", 3);
    chk(lvl === 0, "R6 retry cleared", lvl, 0);
    chk(dly === 0, "R9 level0 delay", dly, 0);

    // R10 end clears retry and tracking
    for (int k = 0; k < 3; k++) begin t_begin(32'h0000_D000); t_abort(); end
    chk(lvl === 1, "R8 three aborts", lvl, 1);
    t_begin(32'h0000_D000);
    for (int k = 0; k < 4; k++) t_mem(32'h0002_0000 + 32'(32*k));
    t_end(); exp_clean("R10 end"); chk(lvl === 0, "R10 retry cleared", lvl, 0);
    t_begin(32'h0000_D000);
    for (int k = 0; k < 4; k++) begin
      t_mem(32'h0003_0000 + 32'(32*k)); exp_clean("R10 entries released");
    end
    t_mem(32'h0003_0080); exp_viol("R10 fifth after release", 1);

    // R7 abort wins over end
    t_begin(32'h0000_E000);
    drv(0,0,0,0,0,0,0,0,1,1);
    chk(rst_o === 1 && lvl === 0, "R7 abort beats end", {rst_o, lvl}, 2'b10);

    // R11 re-begin keeps retry, resets tracking, new pc
    t_begin(32'h0000_E000);
    for (int k = 0; k < 4; k++) t_mem(32'h0004_0000 + 32'(32*k));
    drv(1,32'h0000_E100,0,0,0,0,1,32'h0000_E000,0,0); exp_clean("R11 begin-cycle access ignored");
    for (int k = 0; k < 4; k++) begin
      t_mem(32'h0006_0000 + 32'(32*k)); exp_clean("R11 fresh tracking");
    end
    t_abort();
    chk(rst_o === 1 && rpc_o === 32'h0000_E100, "R7 restart pc latest", rpc_o, 32'h0000_E100);
    chk(lvl === 1, "R11 retry kept", lvl, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule